// File: doc/BRIEF.md
# Storage Device Power State Controller

This block keeps track of the power state of a storage device. The state is one of active, idle, standby or sleep. Decoded host commands move the device between states, and so does a programmable inactivity timer. Each power command is recognised under two opcode values. The idle and standby commands can also program the inactivity timer from the Sector Count value that arrives with them. The timer counts abstract tick strobes and is not tied to wall-clock time.

The block outputs the current state and a busy request for the status logic. While busy is raised, further commands are not taken. It also outputs a spindle-run enable and the power-mode byte that the query command returns. A media-access activity pulse wakes the device from idle or standby and restarts the inactivity count. Once the device is asleep, only a hardware reset or a software reset brings it back to active.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After a hardware reset (`rst_n` low) or a one-cycle `soft_rst` pulse from any state, including sleep, the block is in active (`state_o` = 0) with `busy_o` low, `spin_en_o` high and `mode_code_o` = FFh, and the inactivity timer is disabled.
- R2: An accepted opcode 94h or E0h (immediate standby), or 96h or E2h (standby), puts `state_o` at 2 (standby) with `spin_en_o` low.
- R3: An accepted opcode 95h or E1h (immediate idle), or 97h or E3h (idle), puts `state_o` at 1 (idle) with `spin_en_o` high.
- R4: An accepted opcode 99h or E6h puts `state_o` at 3 (sleep) with `spin_en_o` low. In sleep, every command and every activity pulse is ignored.
- R5: A state-changing command (R2, R3, R4) raises `busy_o` at the clock edge that accepts it and holds it for BUSY_CYCLES cycles. A command presented while `busy_o` is high is ignored.
- R6: An accepted opcode 98h or E5h sets `mode_code_o` to 00h when the device is in standby and to FFh when it is in active or idle. It changes neither the state nor `busy_o`.
- R7: Any other opcode changes neither the state nor `busy_o`.
- R8: Opcodes 96h, E2h, 97h and E3h arm the inactivity timer to `cmd_count` ticks when `cmd_count` is nonzero, and disable it when `cmd_count` is zero. After that many `tick` strobes in active or idle with no activity, the state becomes standby.
- R9: An `activity` pulse in idle or standby moves the state to active and restarts the inactivity count from the armed value.
- R10: The immediate-idle and immediate-standby opcodes leave the timer setting and its running count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous software reset pulse |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 8 | Command opcode |
| cmd_count | input | COUNT_W | Sector Count value sent with the command |
| tick | input | 1 | Timer tick strobe |
| activity | input | 1 | Media-access activity pulse |
| state_o | output | 2 | Current state: 0 active, 1 idle, 2 standby, 3 sleep |
| busy_o | output | 1 | Busy request to the status logic |
| spin_en_o | output | 1 | Spindle-run enable |
| mode_code_o | output | 8 | Power-mode byte returned by the query command |

## Verification
The assertions assume that `cmd_valid`, `activity` and `soft_rst` are single-cycle strobes and that no input is driven during the synchronous reset release. The bench holds to this by driving every input for exactly one cycle, on the falling clock edge. It then sweeps every power opcode in both encodings from each reachable state, and every one of the 256 opcodes from active. Expected states, busy levels and mode bytes are computed in the bench from the opcode table.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

  typedef enum logic [1:0] {
    PS_ACTIVE  = 2'd0,
    PS_IDLE    = 2'd1,
    PS_STANDBY = 2'd2,
    PS_SLEEP   = 2'd3
  } pwr_state_e;

  typedef struct packed {
    logic stby_now;
    logic idle_now;
    logic stby_arm;
    logic idle_arm;
    logic sleep;
    logic query;
  } pwr_cmd_t;

  localparam int NUM_ENC = 2;

  localparam logic [7:0] OPC_STBY_NOW [NUM_ENC] = '{8'h94, 8'hE0};
  localparam logic [7:0] OPC_IDLE_NOW [NUM_ENC] = '{8'h95, 8'hE1};
  localparam logic [7:0] OPC_STBY_ARM [NUM_ENC] = '{8'h96, 8'hE2};
  localparam logic [7:0] OPC_IDLE_ARM [NUM_ENC] = '{8'h97, 8'hE3};
  localparam logic [7:0] OPC_QUERY    [NUM_ENC] = '{8'h98, 8'hE5};
  localparam logic [7:0] OPC_SLEEP    [NUM_ENC] = '{8'h99, 8'hE6};

  localparam logic [7:0] CODE_STANDBY = 8'h00;
  localparam logic [7:0] CODE_SPUN_UP = 8'hFF;

endpackage

// File: rtl/pwr_cmd_decode.sv
module pwr_cmd_decode
  import pwr_state_pkg::*;
(
  input  logic [7:0] op,
  output pwr_cmd_t   cmd
);

  logic [NUM_ENC-1:0] m_stby_now, m_idle_now, m_stby_arm;
  logic [NUM_ENC-1:0] m_idle_arm, m_query, m_sleep;

  for (genvar e = 0; e < NUM_ENC; e++) begin : g_enc
    assign m_stby_now[e] = (op == OPC_STBY_NOW[e]);
    assign m_idle_now[e] = (op == OPC_IDLE_NOW[e]);
    assign m_stby_arm[e] = (op == OPC_STBY_ARM[e]);
    assign m_idle_arm[e] = (op == OPC_IDLE_ARM[e]);
    assign m_query[e]    = (op == OPC_QUERY[e]);
    assign m_sleep[e]    = (op == OPC_SLEEP[e]);
  end

  assign cmd.stby_now = |m_stby_now;
  assign cmd.idle_now = |m_idle_now;
  assign cmd.stby_arm = |m_stby_arm;
  assign cmd.idle_arm = |m_idle_arm;
  assign cmd.query    = |m_query;
  assign cmd.sleep    = |m_sleep;

  // R7: at most one command class matches any opcode
  always_comb begin
    a_r7_one_class: assert ($onehot0({cmd.stby_now, cmd.idle_now, cmd.stby_arm,
                                      cmd.idle_arm, cmd.query, cmd.sleep}));
  end

endmodule

// File: rtl/pwr_idle_timer.sv
module pwr_idle_timer #(
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               arm,
  input  logic [COUNT_W-1:0] arm_val,
  input  logic               restart,
  input  logic               run,
  input  logic               tick,
  output logic               expire
);

  logic [COUNT_W-1:0] period_q, period_d;
  logic [COUNT_W-1:0] remain_q, remain_d;
  logic               upd_en;

  always_comb begin
    period_d = period_q;
    remain_d = remain_q;
    expire   = 1'b0;
    if (clear) begin
      period_d = '0;
      remain_d = '0;
    end else if (arm) begin
      period_d = arm_val;
      remain_d = arm_val;
    end else if (restart) begin
      remain_d = period_q;
    end else if (run && tick && (remain_q != '0)) begin
      remain_d = remain_q - 1'b1;
      expire   = (remain_q == COUNT_W'(1));
    end
  end

  assign upd_en = clear | arm | restart | (run & tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      remain_q <= '0;
    end else if (upd_en) begin
      period_q <= period_d;
      remain_q <= remain_d;
    end
  end

  // R8: a spent or disabled count does not wrap around on its own
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (remain_q == '0 && !arm && !restart) |=> (remain_q == '0));

  // R8: the count never exceeds the armed period
  a_r8_within_period: assert property (@(posedge clk) disable iff (!rst_n)
    (remain_q <= period_q));

endmodule

// File: rtl/pwr_busy_pulse.sv
module pwr_busy_pulse #(
  parameter int BUSY_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic clear,
  output logic busy
);

  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)             cnt_d = '0;
    else if (start)        cnt_d = CW'(BUSY_CYCLES);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 cnt_q <= '0;
    else if (clear || start || (cnt_q != '0))   cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  // R5: the busy window is never longer than BUSY_CYCLES
  a_r5_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= CW'(BUSY_CYCLES)));

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_state_pkg::*;
#(
  parameter int COUNT_W     = 8,
  parameter int BUSY_CYCLES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               cmd_valid,
  input  logic [7:0]         cmd_op,
  input  logic [COUNT_W-1:0] cmd_count,
  input  logic               tick,
  input  logic               activity,
  output logic [1:0]         state_o,
  output logic               busy_o,
  output logic               spin_en_o,
  output logic [7:0]         mode_code_o
);

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pwr_state_e state_q, state_d;
  logic [7:0] code_q, code_d;
  pwr_cmd_t   dec;
  logic       busy, expire, awake;
  logic       accept, go_stby, go_idle, go_sleep, go_mode, arm, wake;

  pwr_cmd_decode u_dec (
    .op  (cmd_op),
    .cmd (dec)
  );

  assign awake    = (state_q == PS_ACTIVE) || (state_q == PS_IDLE);
  assign accept   = cmd_valid && !busy && (state_q != PS_SLEEP) && !soft_rst;
  assign go_stby  = accept && (dec.stby_now || dec.stby_arm);
  assign go_idle  = accept && (dec.idle_now || dec.idle_arm);
  assign go_sleep = accept && dec.sleep;
  assign go_mode  = go_stby || go_idle || go_sleep;
  assign arm      = accept && (dec.stby_arm || dec.idle_arm);
  assign wake     = activity && (state_q != PS_SLEEP) && !soft_rst;

  pwr_idle_timer #(.COUNT_W(COUNT_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clear   (soft_rst),
    .arm     (arm),
    .arm_val (cmd_count),
    .restart (wake),
    .run     (awake),
    .tick    (tick),
    .expire  (expire)
  );

  pwr_busy_pulse #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk   (clk),
    .rst_n (rst_int_n),
    .start (go_mode),
    .clear (soft_rst),
    .busy  (busy)
  );

  // next state: reset, then command, then activity, then timer expiry
  always_comb begin
    state_d = state_q;
    if (soft_rst)      state_d = PS_ACTIVE;
    else if (go_sleep) state_d = PS_SLEEP;
    else if (go_stby)  state_d = PS_STANDBY;
    else if (go_idle)  state_d = PS_IDLE;
    else if (wake)     state_d = PS_ACTIVE;
    else if (expire)   state_d = PS_STANDBY;
  end

  always_comb begin
    code_d = code_q;
    if (soft_rst)
      code_d = CODE_SPUN_UP;
    else if (accept && dec.query)
      code_d = (state_q == PS_STANDBY) ? CODE_STANDBY : CODE_SPUN_UP;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= PS_ACTIVE;
      code_q  <= CODE_SPUN_UP;
    end else begin
      state_q <= state_d;
      if (soft_rst || accept) code_q <= code_d;
    end
  end

  assign state_o     = state_q;
  assign busy_o      = busy;
  assign spin_en_o   = awake;
  assign mode_code_o = code_q;

  // R4: sleep is left only through a reset
  a_r4_sleep_sticky: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == PS_SLEEP && !soft_rst) |=> (state_q == PS_SLEEP));

  // R5: an accepted mode command raises busy on the next cycle
  a_r5_busy_follows: assert property (@(posedge clk) disable iff (!rst_int_n)
    go_mode |=> busy_o);

  // R5: no state change is taken while busy unless by reset
  a_r5_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_o && !soft_rst && !activity && !expire) |=> $stable(state_q));

  // R6: the mode byte moves only on a query or a reset
  a_r6_code_stable: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(accept && dec.query) && !soft_rst |=> $stable(code_q));

  // R1: software reset always lands in active
  a_r1_soft_reset: assert property (@(posedge clk) disable iff (!rst_int_n)
    soft_rst |=> (state_q == PS_ACTIVE) && !busy_o);

endmodule

// File: tb/tb_pwr_state_ctrl.sv
module tb_pwr_state_ctrl;

  logic       clk = 1'b0;
  logic       rst_n, soft_rst, cmd_valid, tick, activity;
  logic [7:0] cmd_op, cmd_count;
  logic [1:0] state_o;
  logic       busy_o, spin_en_o;
  logic [7:0] mode_code_o;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  pwr_state_ctrl #(.COUNT_W(8), .BUSY_CYCLES(2)) dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_count(cmd_count), .tick(tick), .activity(activity),
    .state_o(state_o), .busy_o(busy_o), .spin_en_o(spin_en_o),
    .mode_code_o(mode_code_o)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung (actual cycle %0d, expected end below 150000)", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  function automatic int exp_next(input int cur, input logic [7:0] op);
    case (op)
      8'h94, 8'hE0, 8'h96, 8'hE2: return 2;
      8'h95, 8'hE1, 8'h97, 8'hE3: return 1;
      8'h99, 8'hE6:               return 3;
      default:                    return cur;
    endcase
  endfunction

  function automatic bit is_mode_op(input logic [7:0] op);
    return exp_next(0, op) != 0;
  endfunction

  task automatic cmd(input logic [7:0] op, input logic [7:0] cnt);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_count = cnt;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 8'h00; cmd_count = 8'h00;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic pulse_act();
    @(negedge clk); activity = 1'b1;
    @(negedge clk); activity = 1'b0;
  endtask

  task automatic pulse_soft();
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
  endtask

  task automatic wait_free();
    while (busy_o) @(negedge clk);
  endtask

  task automatic goto_state(input int s);
    pulse_soft();
    if (s == 1) cmd(8'h95, 8'h00);
    if (s == 2) cmd(8'h94, 8'h00);
    wait_free();
  endtask

  localparam logic [7:0] PWR_OPS [12] = '{8'h94, 8'hE0, 8'h95, 8'hE1, 8'h96, 8'hE2,
                                         8'h97, 8'hE3, 8'h98, 8'hE5, 8'h99, 8'hE6};

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0; cmd_valid = 1'b0; tick = 1'b0;
    activity = 1'b0; cmd_op = 8'h00; cmd_count = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_eq("R1 state after reset", state_o, 0);
    chk_eq("R1 busy after reset", busy_o, 0);
    chk_eq("R1 spin after reset", spin_en_o, 1);
    chk_eq("R1 code after reset", mode_code_o, 8'hFF);

    // R2 R3 R4 R5: every power opcode from each awake state
    for (int s = 0; s < 3; s++) begin
      for (int i = 0; i < 12; i++) begin
        goto_state(s);
        cmd(PWR_OPS[i], 8'h00);
        chk_eq($sformatf("R2/R3/R4 op %0h from %0d", PWR_OPS[i], s),
               state_o, exp_next(s, PWR_OPS[i]));
        chk_eq($sformatf("R5 busy op %0h", PWR_OPS[i]), busy_o, is_mode_op(PWR_OPS[i]));
        chk_eq($sformatf("R2/R3 spin op %0h", PWR_OPS[i]), spin_en_o,
               (exp_next(s, PWR_OPS[i]) < 2) ? 1 : 0);
        wait_free();
      end
    end

    // R7: all 256 opcodes from active
    for (int op = 0; op < 256; op++) begin
      goto_state(0);
      cmd(op[7:0], 8'h00);
      if (!is_mode_op(op[7:0]))
        chk_eq($sformatf("R7 op %0h state/busy", op), {state_o, busy_o}, 0);
      else
        chk_eq($sformatf("R5 op %0h busy", op), busy_o, 1);
      wait_free();
    end

    // R5: busy window length and ignored command while busy
    goto_state(0);
    cmd(8'h94, 8'h00);
    chk_eq("R5 busy cycle 1", busy_o, 1);
    cmd(8'hE1, 8'h00);
    chk_eq("R5 command during busy ignored", state_o, 2);
    chk_eq("R5 busy cleared after window", busy_o, 0);

    // R6 query in each state
    goto_state(2); cmd(8'h98, 8'h00);
    chk_eq("R6 code in standby", mode_code_o, 8'h00);
    chk_eq("R6 query no busy", busy_o, 0);
    goto_state(1); cmd(8'hE5, 8'h00);
    chk_eq("R6 code in idle", mode_code_o, 8'hFF);
    chk_eq("R6 query keeps idle", state_o, 1);
    goto_state(2); cmd(8'hE5, 8'h00);
    chk_eq("R6 code in standby enc2", mode_code_o, 8'h00);
    pulse_soft();
    chk_eq("R1 soft reset restores code", mode_code_o, 8'hFF);

    // R4 sleep ignores everything
    goto_state(2); cmd(8'h98, 8'h00);
    cmd(8'h99, 8'h00); wait_free();
    cmd(8'h95, 8'h00);
    chk_eq("R4 idle command ignored in sleep", state_o, 3);
    chk_eq("R4 no busy in sleep", busy_o, 0);
    cmd(8'h98, 8'h00);
    chk_eq("R4 query ignored in sleep", mode_code_o, 8'h00);
    pulse_act();
    chk_eq("R4 activity ignored in sleep", state_o, 3);
    chk_eq("R4 spin off in sleep", spin_en_o, 0);
    pulse_soft();
    chk_eq("R1 soft reset leaves sleep", state_o, 0);
    cmd(8'hE6, 8'h00); wait_free();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_eq("R1 hardware reset leaves sleep", state_o, 0);

    // R8 timer arming and expiry
    for (int n = 1; n <= 6; n++) begin
      goto_state(0);
      cmd(8'h97, n[7:0]); wait_free();
      for (int t = 1; t < n; t++) pulse_tick();
      chk_eq($sformatf("R8 idle before %0d ticks", n), state_o, 1);
      pulse_tick();
      chk_eq($sformatf("R8 standby after %0d ticks", n), state_o, 2);
    end
    goto_state(0);
    cmd(8'hE3, 8'h00); wait_free();
    for (int t = 0; t < 20; t++) pulse_tick();
    chk_eq("R8 zero count disables timer", state_o, 1);
    // zero count clears an earlier arming
    goto_state(0);
    cmd(8'h97, 8'h02); wait_free();
    cmd(8'h97, 8'h00); wait_free();
    for (int t = 0; t < 5; t++) pulse_tick();
    chk_eq("R8 zero count disarms", state_o, 1);
    // soft reset disables timer
    goto_state(0);
    cmd(8'h97, 8'h02); wait_free();
    pulse_soft();
    for (int t = 0; t < 5; t++) pulse_tick();
    chk_eq("R1 soft reset disarms timer", state_o, 0);

    // R9 activity wakes and restarts count
    goto_state(2);
    pulse_act();
    chk_eq("R9 activity wakes standby", state_o, 0);
    chk_eq("R9 spin on after wake", spin_en_o, 1);
    goto_state(0);
    cmd(8'h97, 8'h03); wait_free();
    pulse_tick(); pulse_tick();
    pulse_act();
    chk_eq("R9 activity idle to active", state_o, 0);
    pulse_tick(); pulse_tick();
    chk_eq("R9 count restarted", state_o, 0);
    pulse_tick();
    chk_eq("R9 expiry after restart", state_o, 2);
    // standby command arms, count starts after wake
    goto_state(0);
    cmd(8'hE2, 8'h02); wait_free();
    pulse_tick(); pulse_tick();
    chk_eq("R8 no count in standby", state_o, 2);
    pulse_act(); pulse_tick();
    chk_eq("R8 woken count running", state_o, 0);
    pulse_tick();
    chk_eq("R8 standby from active", state_o, 2);

    // R10 immediate opcode keeps the running count
    goto_state(0);
    cmd(8'h97, 8'h03); wait_free();
    pulse_tick();
    cmd(8'hE1, 8'h09); wait_free();
    pulse_tick();
    chk_eq("R10 still idle", state_o, 1);
    pulse_tick();
    chk_eq("R10 count kept across immediate idle", state_o, 2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule